// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripheral sources and four external request pins, and presents one normal interrupt request to a processor core together with the number and priority of the source to service. Every normal source has its own enable, a 3-bit priority (eight levels) and a trigger mode. Internal sources choose between level and edge detection. External sources can also choose the polarity, and they are resynchronized before detection.

A second output, the fast request, is driven only by one dedicated external pin through its own two-flop synchronizer. No configuration and no peripheral source can reach it.

Software acknowledges the presented source with a one-cycle `ack_i` pulse. The acknowledge pushes that source's priority onto an eight-entry nesting stack. After that, only sources of strictly higher priority can raise the normal request again. A one-cycle `eoi_i` pulse pops the stack and restores the previous floor. Configuration is written one source at a time through a simple write strobe.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `fiq_o` equals the value `ext_fiq_i` had two clock edges earlier (two-flop synchronizer). Internal sources, external request pins, configuration and the acknowledge handshake never change it.
- R2: Source indices 0 to N_INT-1 are the internal inputs `int_src_i[i]`. Indices N_INT to N_INT+3 are `ext_irq_i[0..3]`. `irq_o` is high while at least one enabled source qualifies, and `irq_id_o` is then below N_INT+4.
- R3: A cycle with `cfg_we_i` high writes the enable, priority and mode of source `cfg_sel_i`. The new settings take effect from the next cycle. A write whose index is N_INT+4 or higher changes nothing.
- R4: Mode encoding for internal sources: `cfg_mode_i[1]`=0 selects active-high level, and 1 selects rising edge. Bit 0 is ignored, so mode 01 behaves as high level and mode 11 as rising edge.
- R5: Mode encoding for external sources: 00 high level, 01 low level, 10 rising edge, 11 falling edge. The pin is seen after two flops. A level change shows on `irq_o` two edges after the pin changes, and an edge latches its pending bit on the third edge.
- R6: Among qualifying sources, the one with the numerically largest priority (0 to 7) is presented in `irq_id_o`/`irq_prio_o`. On equal priority, the lower index wins.
- R7: An edge-mode source latches its pending bit on its configured edge even while disabled. Only an acknowledge of that source clears the bit, and a newly detected edge in the same cycle keeps it set. A disabled source never drives `irq_o`.
- R8: `ack_i` while `irq_o` is high pushes `irq_prio_o`, increments `nest_depth_o` and clears the presented source's pending bit. While the depth is nonzero, only sources with priority strictly above the top of the stack qualify. `ack_i` while `irq_o` is low is ignored.
- R9: `eoi_i` pops one stack entry and restores the previous floor. It is ignored at depth 0, and it is ignored in any cycle where `ack_i` is also high.
- R10: After reset, every source is disabled with priority 0 and mode 00, no pending bits are set, the depth is 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_src_i | input | N_INT | Internal peripheral request lines (synchronous) |
| ext_irq_i | input | 4 | External normal request pins (asynchronous) |
| ext_fiq_i | input | 1 | External fast request pin (asynchronous) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | ID_W | Source index to configure |
| cfg_en_i | input | 1 | Enable value written |
| cfg_prio_i | input | 3 | Priority value written |
| cfg_mode_i | input | 2 | Trigger mode written |
| ack_i | input | 1 | Acknowledge of the presented source |
| eoi_i | input | 1 | End of service |
| irq_o | output | 1 | Normal interrupt request |
| irq_id_o | output | ID_W | Index of the presented source |
| irq_prio_o | output | 3 | Priority of the presented source |
| fiq_o | output | 1 | Fast interrupt request |
| nest_depth_o | output | DEPTH_W | Number of entries on the nesting stack |

## Verification
The checker verifies several properties on every cycle. The fast output can only be high if the pin was high two edges before. Every presented index is in range, and the depth never exceeds the stack size. An effective acknowledge raises the depth by one and leaves only a strictly higher priority presented. An end-of-service pops exactly one entry, and the depth holds when neither handshake acts. Other behaviours only show up over a sequence of inputs and are covered by the bench scenarios: the trigger modes and their synchronizer latency, tie-breaking by index, edge latching while disabled, ignored out-of-range writes, and the restored floor after a nested pop.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int PRIO_W   = 3;
    localparam int N_LEVELS = 1 << PRIO_W;
    localparam int N_EXT    = 4;

    typedef logic [PRIO_W-1:0] prio_t;

    // bit 1 selects edge detection, bit 0 inverts (external sources only)
    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        logic  en;
        prio_t prio;
        trig_e trig;
    } src_cfg_t;

    localparam src_cfg_t CFG_RESET = '{en: 1'b0, prio: '0, trig: TRIG_HIGH};

    function automatic logic trig_is_edge(trig_e t);
        return t[1];
    endfunction

    function automatic logic trig_inverted(trig_e t, logic pol_capable);
        return pol_capable & t[0];
    endfunction

    // a source clears the nesting floor when no service is active or it ranks above it
    function automatic logic above_floor(prio_t p, logic busy, prio_t floor);
        return !busy || (p > floor);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d_i;
            stable_q <= meta_q;
        end
    end

    assign q_o = stable_q;

endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect
    import irq_pkg::*;
#(
    parameter bit POL_CAPABLE = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl_i,
    input  src_cfg_t cfg_i,
    input  logic     clr_i,
    output logic     req_o
);

    logic prev_q;
    logic pend_q;
    logic inv;
    logic seen_edge;

    always_comb begin
        inv       = trig_inverted(cfg_i.trig, POL_CAPABLE);
        seen_edge = inv ? (prev_q & ~lvl_i) : (lvl_i & ~prev_q);
        req_o     = trig_is_edge(cfg_i.trig) ? pend_q : (lvl_i ^ inv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (trig_is_edge(cfg_i.trig) && seen_edge) begin
                pend_q <= 1'b1;
            end else if (clr_i) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_pkg::*;
#(
    parameter int N    = 12,
    parameter int ID_W = 4
) (
    input  logic  [N-1:0] cand_i,
    input  prio_t [N-1:0] prio_i,
    output logic          hit_o,
    output logic [ID_W-1:0] id_o,
    output prio_t         prio_o
);

    // scan from the top index down; ">=" lets a lower index take over a tie
    always_comb begin
        hit_o  = 1'b0;
        id_o   = '0;
        prio_o = '0;
        for (int s = N - 1; s >= 0; s--) begin
            if (cand_i[s] && (!hit_o || prio_i[s] >= prio_o)) begin
                hit_o  = 1'b1;
                id_o   = ID_W'(s);
                prio_o = prio_i[s];
            end
        end
    end

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
    import irq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_i,
    input  prio_t              push_prio_i,
    input  logic               pop_i,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               busy_o,
    output prio_t              top_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    prio_t [DEPTH-1:0]  slot_q;
    logic [DEPTH_W-1:0] cnt_q;
    logic [DEPTH_W-1:0] below;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (push_i && (cnt_q < DEPTH_W'(DEPTH))) begin
            slot_q[cnt_q[IDX_W-1:0]] <= push_prio_i;
            cnt_q                    <= cnt_q + DEPTH_W'(1);
        end else if (pop_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - DEPTH_W'(1);
        end
    end

    always_comb begin
        below   = cnt_q - DEPTH_W'(1);
        busy_o  = (cnt_q != '0);
        top_o   = busy_o ? slot_q[below[IDX_W-1:0]] : '0;
        depth_o = cnt_q;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter  int N_INT      = 8,
    parameter  int NEST_DEPTH = 8,
    localparam int N_SRC      = N_INT + N_EXT,
    localparam int ID_W       = $clog2(N_SRC),
    localparam int DEPTH_W    = $clog2(NEST_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_INT-1:0]   int_src_i,
    input  logic [N_EXT-1:0]   ext_irq_i,
    input  logic               ext_fiq_i,
    input  logic               cfg_we_i,
    input  logic [ID_W-1:0]    cfg_sel_i,
    input  logic               cfg_en_i,
    input  logic [PRIO_W-1:0]  cfg_prio_i,
    input  logic [1:0]         cfg_mode_i,
    input  logic               ack_i,
    input  logic               eoi_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    irq_id_o,
    output logic [PRIO_W-1:0]  irq_prio_o,
    output logic               fiq_o,
    output logic [DEPTH_W-1:0] nest_depth_o
);

    src_cfg_t [N_SRC-1:0] cfg_q;
    logic                 sel_ok;

    logic [N_EXT-1:0]     ext_lvl;
    logic [N_SRC-1:0]     raw_lvl;
    logic [N_SRC-1:0]     src_req;
    logic [N_SRC-1:0]     src_clr;
    logic [N_SRC-1:0]     cand;
    prio_t [N_SRC-1:0]    prio_vec;

    logic                 win_hit;
    logic [ID_W-1:0]      win_id;
    prio_t                win_prio;
    logic                 ack_take;
    logic                 stk_busy;
    prio_t                stk_top;

    // configuration registers, one write per cycle
    always_comb sel_ok = (int'(cfg_sel_i) < N_SRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= {N_SRC{CFG_RESET}};
        end else if (cfg_we_i && sel_ok) begin
            cfg_q[cfg_sel_i] <= '{en: cfg_en_i, prio: cfg_prio_i, trig: trig_e'(cfg_mode_i)};
        end
    end

    // external pins cross into this clock domain first
    irq_sync #(.W(N_EXT)) u_ext_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ext_irq_i),
        .q_o (ext_lvl)
    );

    // the fast path is a pin synchronizer and nothing else
    irq_sync #(.W(1)) u_fiq_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ext_fiq_i),
        .q_o (fiq_o)
    );

    assign raw_lvl = {ext_lvl, int_src_i};

    // per-source detection; only external slots honour the polarity bit
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        if (s < N_INT) begin : g_int
            irq_src_detect #(.POL_CAPABLE(1'b0)) u_det (
                .clk   (clk),
                .rst   (rst),
                .lvl_i (raw_lvl[s]),
                .cfg_i (cfg_q[s]),
                .clr_i (src_clr[s]),
                .req_o (src_req[s])
            );
        end else begin : g_ext
            irq_src_detect #(.POL_CAPABLE(1'b1)) u_det (
                .clk   (clk),
                .rst   (rst),
                .lvl_i (raw_lvl[s]),
                .cfg_i (cfg_q[s]),
                .clr_i (src_clr[s]),
                .req_o (src_req[s])
            );
        end

        always_comb begin
            prio_vec[s] = cfg_q[s].prio;
            cand[s]     = cfg_q[s].en & src_req[s]
                        & above_floor(cfg_q[s].prio, stk_busy, stk_top);
            src_clr[s]  = ack_take && (win_id == ID_W'(s));
        end
    end

    irq_prio_resolve #(.N(N_SRC), .ID_W(ID_W)) u_resolve (
        .cand_i (cand),
        .prio_i (prio_vec),
        .hit_o  (win_hit),
        .id_o   (win_id),
        .prio_o (win_prio)
    );

    assign ack_take = ack_i & win_hit;

    irq_nest_stack #(.DEPTH(NEST_DEPTH), .DEPTH_W(DEPTH_W)) u_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (ack_take),
        .push_prio_i (win_prio),
        .pop_i       (eoi_i & ~ack_i),
        .depth_o     (nest_depth_o),
        .busy_o      (stk_busy),
        .top_o       (stk_top)
    );

    assign irq_o      = win_hit;
    assign irq_id_o   = win_id;
    assign irq_prio_o = win_prio;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter  int N_INT      = 8,
    parameter  int NEST_DEPTH = 8,
    localparam int N_SRC      = N_INT + irq_pkg::N_EXT,
    localparam int ID_W       = $clog2(N_SRC),
    localparam int DEPTH_W    = $clog2(NEST_DEPTH + 1)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ext_fiq_i,
    input logic                      ack_i,
    input logic                      eoi_i,
    input logic                      irq_o,
    input logic [ID_W-1:0]           irq_id_o,
    input logic [irq_pkg::PRIO_W-1:0] irq_prio_o,
    input logic                      fiq_o,
    input logic [DEPTH_W-1:0]        nest_depth_o
);

    AST_FIQ_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> $past(ext_fiq_i, 2)); // R1

    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (int'(irq_id_o) < N_SRC)); // R2

    AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
        int'(nest_depth_o) <= NEST_DEPTH); // R8

    AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> (int'(nest_depth_o) == int'($past(nest_depth_o)) + 1)); // R8

    AST_ACK_RAISES_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> (!irq_o || (irq_prio_o > $past(irq_prio_o)))); // R8

    AST_EOI_POPS: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !ack_i && (nest_depth_o != '0)) |=>
            (int'(nest_depth_o) == int'($past(nest_depth_o)) - 1)); // R9

    AST_DEPTH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ack_i && !eoi_i) |=> $stable(nest_depth_o)); // R9

    AST_EOI_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !ack_i && (nest_depth_o == '0)) |=> (nest_depth_o == '0)); // R9

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_INT(N_INT), .NEST_DEPTH(NEST_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_fiq_i    (ext_fiq_i),
    .ack_i        (ack_i),
    .eoi_i        (eoi_i),
    .irq_o        (irq_o),
    .irq_id_o     (irq_id_o),
    .irq_prio_o   (irq_prio_o),
    .fiq_o        (fiq_o),
    .nest_depth_o (nest_depth_o)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

    localparam int N_INT   = 8;
    localparam int N_EXT   = 4;
    localparam int N_SRC   = N_INT + N_EXT;
    localparam int ID_W    = 4;
    localparam int DEPTH_W = 4;
    localparam int PW      = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N_INT-1:0]   int_src = '0;
    logic [N_EXT-1:0]   ext_irq = '0;
    logic               ext_fiq = 1'b0;
    logic               cfg_we = 1'b0;
    logic [ID_W-1:0]    cfg_sel = '0;
    logic               cfg_en = 1'b0;
    logic [PW-1:0]      cfg_prio = '0;
    logic [1:0]         cfg_mode = '0;
    logic               ack = 1'b0;
    logic               eoi = 1'b0;
    logic               irq_o;
    logic [ID_W-1:0]    irq_id_o;
    logic [PW-1:0]      irq_prio_o;
    logic               fiq_o;
    logic [DEPTH_W-1:0] nest_depth_o;

    always #2 clk = ~clk;

    irq_prio_ctrl #(.N_INT(N_INT), .NEST_DEPTH(8)) u_dut (
        .clk (clk), .rst (rst), .int_src_i (int_src), .ext_irq_i (ext_irq),
        .ext_fiq_i (ext_fiq), .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel),
        .cfg_en_i (cfg_en), .cfg_prio_i (cfg_prio), .cfg_mode_i (cfg_mode),
        .ack_i (ack), .eoi_i (eoi), .irq_o (irq_o), .irq_id_o (irq_id_o),
        .irq_prio_o (irq_prio_o), .fiq_o (fiq_o), .nest_depth_o (nest_depth_o)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_req = "R10";

    // behavioural reference state
    bit m_en[N_SRC];
    int m_prio[N_SRC];
    int m_mode[N_SRC];
    bit m_pend[N_SRC];
    bit m_prev[N_INT];
    bit m_e1[N_EXT], m_e2[N_EXT], m_e3[N_EXT];
    bit m_f1, m_f2;
    int m_stk[$];

    function automatic bit m_req(int s);
        bit lv;
        if (m_mode[s] >= 2) return m_pend[s];
        lv = (s < N_INT) ? int_src[s] : m_e2[s-N_INT];
        if (s >= N_INT && m_mode[s] == 1) return !lv;
        return lv;
    endfunction

    function automatic void m_pick(output int id, output int pr);
        int floor_p;
        floor_p = (m_stk.size() > 0) ? m_stk[$] : -1;
        id = -1;
        pr = -1;
        for (int s = 0; s < N_SRC; s++) begin
            if (m_en[s] && m_req(s) && m_prio[s] > floor_p && m_prio[s] > pr) begin
                id = s;
                pr = m_prio[s];
            end
        end
    endfunction

    always @(posedge clk) begin
        int id, pr;
        bit fire[N_SRC];
        if (rst) begin
            for (int s = 0; s < N_SRC; s++) begin
                m_en[s] = 0; m_prio[s] = 0; m_mode[s] = 0; m_pend[s] = 0;
            end
            for (int s = 0; s < N_INT; s++) m_prev[s] = 0;
            for (int j = 0; j < N_EXT; j++) begin m_e1[j] = 0; m_e2[j] = 0; m_e3[j] = 0; end
            m_f1 = 0; m_f2 = 0;
            m_stk.delete();
        end else begin
            m_pick(id, pr);
            for (int s = 0; s < N_SRC; s++) begin
                fire[s] = 0;
                if (m_mode[s] >= 2) begin
                    if (s < N_INT) fire[s] = int_src[s] && !m_prev[s];
                    else if (m_mode[s] == 3) fire[s] = !m_e2[s-N_INT] && m_e3[s-N_INT];
                    else fire[s] = m_e2[s-N_INT] && !m_e3[s-N_INT];
                end
            end
            if (ack && id >= 0) begin
                m_stk.push_back(pr);
                m_pend[id] = 0;
            end else if (!ack && eoi && m_stk.size() > 0) begin
                void'(m_stk.pop_back());
            end
            for (int s = 0; s < N_SRC; s++) if (fire[s]) m_pend[s] = 1;
            for (int s = 0; s < N_INT; s++) m_prev[s] = int_src[s];
            for (int j = 0; j < N_EXT; j++) begin
                m_e3[j] = m_e2[j]; m_e2[j] = m_e1[j]; m_e1[j] = ext_irq[j];
            end
            m_f2 = m_f1; m_f1 = ext_fiq;
            if (cfg_we && int'(cfg_sel) < N_SRC) begin
                m_en[cfg_sel] = cfg_en; m_prio[cfg_sel] = cfg_prio; m_mode[cfg_sel] = cfg_mode;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int id, pr;
        m_pick(id, pr);
        chk(fiq_o == m_f2, "R1", fiq_o, m_f2);
        chk(int'(nest_depth_o) == m_stk.size(), "R8", nest_depth_o, m_stk.size());
        chk(irq_o == (id >= 0), cur_req, irq_o, id >= 0);
        if (id >= 0 && irq_o) begin
            chk(int'(irq_id_o) == id, cur_req, irq_id_o, id);
            chk(int'(irq_prio_o) == pr, cur_req, irq_prio_o, pr);
        end
    endtask

    task automatic tick();
        #1 compare();
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic expect_id(int exp, string tag);
        int act;
        act = irq_o ? int'(irq_id_o) : -1;
        chk(act == exp, tag, act, exp);
    endtask

    task automatic cfgw(int sel, bit en, int pr, int mode);
        cfg_we = 1; cfg_sel = ID_W'(sel); cfg_en = en; cfg_prio = PW'(pr); cfg_mode = 2'(mode);
        tick();
        cfg_we = 0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic do_eoi();
        eoi = 1; tick(); eoi = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R10 reset state
        cur_req = "R10";
        tick();
        expect_id(-1, "R10");
        chk(nest_depth_o == 0 && fiq_o == 0, "R10", nest_depth_o, 0);

        // R2/R3 write then level request
        cur_req = "R3";
        int_src[2] = 1;
        cfgw(2, 1, 3, 0);
        expect_id(2, "R2");
        cfgw(12, 1, 7, 0);
        cfgw(15, 1, 7, 2);
        tick();
        expect_id(2, "R3");

        // R4 internal edge modes, polarity bit ignored
        cur_req = "R4";
        cfgw(5, 1, 5, 2);
        int_src[5] = 1; tick(); int_src[5] = 0; ticks(2);
        expect_id(5, "R4");
        cfgw(6, 1, 6, 3);
        int_src[6] = 1; tick(); int_src[6] = 0; ticks(2);
        expect_id(6, "R4");

        // R8 acknowledge and nesting floor
        cur_req = "R8";
        do_ack();
        expect_id(-1, "R8");
        chk(nest_depth_o == 1, "R8", nest_depth_o, 1);
        do_ack();
        chk(nest_depth_o == 1, "R8", nest_depth_o, 1);
        int_src[0] = 1;
        cfgw(0, 1, 7, 0);
        expect_id(0, "R8");
        do_ack();
        expect_id(-1, "R8");

        // R9 end of service
        cur_req = "R9";
        do_eoi();
        expect_id(0, "R9");
        int_src[0] = 0; tick();
        do_eoi();
        expect_id(5, "R9");
        ack = 1; eoi = 1; tick(); ack = 0; eoi = 0;
        chk(nest_depth_o == 1, "R9", nest_depth_o, 1);
        do_eoi();
        expect_id(2, "R9");
        do_eoi();
        chk(nest_depth_o == 0, "R9", nest_depth_o, 0);
        expect_id(2, "R9");

        // R6 equal priority: lower index wins
        cur_req = "R6";
        int_src[1] = 1; int_src[3] = 1;
        cfgw(3, 1, 3, 0);
        expect_id(2, "R6");
        cfgw(1, 1, 3, 0);
        expect_id(1, "R6");
        cfgw(1, 0, 3, 0);
        expect_id(2, "R6");

        // R7 masked source still latches its edge
        cur_req = "R7";
        cfgw(4, 0, 7, 2);
        int_src[4] = 1; tick(); int_src[4] = 0; ticks(2);
        expect_id(2, "R7");
        cfgw(4, 1, 7, 2);
        expect_id(4, "R7");
        do_ack();
        do_eoi();
        expect_id(2, "R7");

        // clean up, then R4 polarity bit on an internal level source
        int_src = '0;
        cfgw(2, 0, 3, 0);
        cfgw(3, 0, 3, 0);
        expect_id(-1, "R2");
        cur_req = "R4";
        int_src[7] = 1;
        cfgw(7, 1, 1, 1);
        expect_id(7, "R4");
        int_src[7] = 0; tick();
        expect_id(-1, "R4");
        cfgw(7, 0, 1, 1);

        // R5 external modes and synchronizer latency
        cur_req = "R5";
        cfgw(8, 1, 4, 0);
        ext_irq[0] = 1; tick();
        expect_id(-1, "R5");
        tick();
        expect_id(8, "R5");
        ext_irq[0] = 0; ticks(2);
        expect_id(-1, "R5");
        cfgw(8, 0, 4, 0);
        cfgw(9, 1, 4, 1);
        expect_id(9, "R5");
        ext_irq[1] = 1; ticks(2);
        expect_id(-1, "R5");
        cfgw(9, 0, 4, 1);
        cfgw(10, 1, 5, 2);
        ext_irq[2] = 1; tick(); ext_irq[2] = 0; ticks(4);
        expect_id(10, "R5");
        do_ack(); do_eoi();
        expect_id(-1, "R5");
        cfgw(10, 0, 5, 2);
        cfgw(11, 1, 6, 3);
        ext_irq[3] = 1; ticks(4);
        expect_id(-1, "R5");
        ext_irq[3] = 0; ticks(2);
        expect_id(-1, "R5");
        tick();
        expect_id(11, "R5");
        do_ack(); do_eoi();

        // R1 fast path only follows its own pin
        cur_req = "R1";
        int_src = '1;
        cfgw(0, 1, 7, 0);
        ticks(2);
        chk(fiq_o == 0, "R1", fiq_o, 0);
        ext_fiq = 1; tick();
        chk(fiq_o == 0, "R1", fiq_o, 0);
        tick();
        chk(fiq_o == 1, "R1", fiq_o, 1);
        do_ack();
        chk(fiq_o == 1, "R1", fiq_o, 1);
        ext_fiq = 0; ticks(2);
        chk(fiq_o == 0, "R1", fiq_o, 0);
        do_eoi();
        ticks(3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule